// File: doc/BRIEF.md
# Mode-Configurable SPI Bus Master

This block is a full-duplex serial master for a four-wire synchronous serial bus. A host pulses `start` together with a data word, the index of the target slave, a clock divider, the clock polarity and phase bits, and a lead delay. The block then drives one active-low select line, waits the programmed lead time, and generates the serial clock. On every serial clock cycle it moves one bit out on `mosi` and one bit in from `miso`. When the last bit has been exchanged, it releases the select line and pulses `done` with the received word.

The serial clock runs at the system clock divided by 2×(`clk_div`+1). The lead delay gives slow slaves time to get ready before the first clock edge, for example to finish a conversion. The select decode is one-hot, so two slaves can never drive `miso` at the same time. An index that matches no slave runs the transfer with every select line held high.

Top module: `spi_bus_master`

## Requirements
- R1: After reset, `ss_n` is all ones, `sck` is 0, `mosi` is 0, and `busy` and `done` are 0.
- R2: Select bit i of `ss_n` (bit i for index i) goes low from the cycle after `start` is accepted until the transfer finishes. No other select bit goes low. An index of `NUM_SLAVES` or more leaves every select bit high. At most one bit of `ss_n` is ever low.
- R3: After select asserts, `sck` holds its idle level for (`lead_dly`+1)+(`clk_div`+1) system cycles before its first edge.
- R4: While idle, `sck` follows the `cpol` input. During a transfer, it uses the value of `cpol` latched at start: 0 gives an idle-low clock and 1 gives an idle-high clock. Each half period lasts `clk_div`+1 system cycles, and there are exactly 2×`DATA_W` edges per transfer.
- R5: With `cpha`=0, the MSB is on `mosi` from the start of select. `miso` is captured on each leading edge (the edge away from the idle level), and `mosi` changes only on trailing edges.
- R6: With `cpha`=1, `miso` is captured on each trailing edge. `mosi` changes on leading edges, starting from the second one.
- R7: Words are exchanged MSB first in both directions. `rx_data` equals the bits the slave shifted out on `miso`. When no slave is selected and `miso` rests high, `rx_data` is all ones.
- R8: After the last edge, `sck` stays idle for one further half period. Then `ss_n` returns to all ones and `done` is high for exactly one cycle, with `busy` low and `rx_data` valid.
- R9: While `busy` is high, `start` and all configuration and data inputs have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted while idle) |
| tx_data | input | DATA_W | Word to send |
| slave_idx | input | IDX_W | Index of the target slave |
| clk_div | input | DIV_W | Half-period length minus one, in system cycles |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| lead_dly | input | DLY_W | Wait after select minus one, in system cycles |
| miso | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | NUM_SLAVES | Active-low slave selects |
| rx_data | output | DATA_W | Received word, valid with done |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the block with `DATA_W`=8, `NUM_SLAVES`=3, and 4-bit divider and delay fields. With three slaves and a two-bit index, index 3 matches no slave, so the bench can drive an out-of-range selection. The 4-bit fields make the largest divider and lead delay (15) cheap to reach. All four polarity and phase combinations are run against a behavioural slave. That slave captures and shifts according to the mode, so the ordering of captures and changes shows up in the exchanged words.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
  parameter int NUM_SLAVES = 3,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  drop,
  input  logic [IDX_W-1:0]      idx,
  output logic [NUM_SLAVES-1:0] ss_n
);
  for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic sel_q, sel_d;

    always_comb begin
      sel_d = sel_q;
      if (load)      sel_d = (idx != MY_IDX);
      else if (drop) sel_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b1;
      else        sel_q <= sel_d;
    end

    assign ss_n[i] = sel_q;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift_out,
  input  logic              capture,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load)           tx_d = tx_word;
    else if (shift_out) tx_d = {tx_q[DATA_W-2:0], 1'b0};
    if (load)           rx_d = '0;
    else if (capture)   rx_d = {rx_q[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = tx_q[DATA_W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_bus_master.sv
module spi_bus_master
  import spi_master_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_SLAVES = 3,
  parameter int DIV_W      = 4,
  parameter int DLY_W      = 4,
  parameter int IDX_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  start,
  input  logic [DATA_W-1:0]     tx_data,
  input  logic [IDX_W-1:0]      slave_idx,
  input  logic [DIV_W-1:0]      clk_div,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic [DLY_W-1:0]      lead_dly,
  input  logic                  miso,
  output logic                  sck,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] ss_n,
  output logic [DATA_W-1:0]     rx_data,
  output logic                  done,
  output logic                  busy
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam int BC_W  = $clog2(DATA_W + 1);

  logic rst_sync_n;

  xfer_state_e       state_q, state_d;
  logic [DLY_W-1:0]  lead_q, lead_d, dly_q, dly_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              cpol_q, cpol_d, cpha_q, cpha_d;
  logic [EC_W-1:0]   edge_q, edge_d;
  logic [BC_W-1:0]   bits_q, bits_d;
  logic              sck_q, sck_d, done_q, done_d;
  logic [DATA_W-1:0] rx_out_q, rx_out_d;

  logic accept, tick, last_half, toggle, finish, leading, cap_edge;
  logic do_capture, do_shift;
  logic [DATA_W-1:0] rx_word;

  spi_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_sync_n)
  );

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (state_q == ST_XFER),
    .div   (div_q),
    .tick  (tick)
  );

  always_comb begin
    accept     = (state_q == ST_IDLE) && start;
    last_half  = (edge_q == EC_W'(EDGES));
    toggle     = tick && !last_half;
    finish     = tick && last_half;
    leading    = (sck_q == cpol_q);
    cap_edge   = leading ^ cpha_q;
    do_capture = toggle && cap_edge;
    do_shift   = toggle && !cap_edge && (bits_q != '0) && (bits_q != BC_W'(DATA_W));
  end

  spi_sel_decode #(.NUM_SLAVES(NUM_SLAVES), .IDX_W(IDX_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (accept),
    .drop  (finish),
    .idx   (slave_idx),
    .ss_n  (ss_n)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (accept),
    .tx_word   (tx_data),
    .shift_out (do_shift),
    .capture   (do_capture),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_comb begin
    state_d  = state_q;
    lead_d   = lead_q;
    dly_d    = dly_q;
    div_d    = div_q;
    cpol_d   = cpol_q;
    cpha_d   = cpha_q;
    edge_d   = edge_q;
    bits_d   = bits_q;
    sck_d    = sck_q;
    done_d   = 1'b0;
    rx_out_d = rx_out_q;
    unique case (state_q)
      ST_IDLE: begin
        sck_d = cpol;
        if (accept) begin
          state_d = ST_LEAD;
          lead_d  = '0;
          dly_d   = lead_dly;
          div_d   = clk_div;
          cpol_d  = cpol;
          cpha_d  = cpha;
          edge_d  = '0;
          bits_d  = '0;
        end
      end
      ST_LEAD: begin
        if (lead_q == dly_q) state_d = ST_XFER;
        else                 lead_d  = lead_q + DLY_W'(1);
      end
      ST_XFER: begin
        if (toggle) begin
          sck_d  = ~sck_q;
          edge_d = edge_q + EC_W'(1);
        end
        if (do_capture) bits_d = bits_q + BC_W'(1);
        if (finish) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          rx_out_d = rx_word;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      lead_q   <= '0;
      dly_q    <= '0;
      div_q    <= '0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      edge_q   <= '0;
      bits_q   <= '0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      rx_out_q <= '0;
    end else begin
      state_q  <= state_d;
      lead_q   <= lead_d;
      dly_q    <= dly_d;
      div_q    <= div_d;
      cpol_q   <= cpol_d;
      cpha_q   <= cpha_d;
      edge_q   <= edge_d;
      bits_q   <= bits_d;
      sck_q    <= sck_d;
      done_q   <= done_d;
      rx_out_q <= rx_out_d;
    end
  end

  assign sck     = sck_q;
  assign done    = done_q;
  assign busy    = (state_q != ST_IDLE);
  assign rx_data = rx_out_q;
endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk #(
  parameter int NUM_SLAVES = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  sck,
  input logic                  mosi,
  input logic [NUM_SLAVES-1:0] ss_n
);
  // R2
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));

  // R2
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ss_n));

  // R2
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&ss_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((&ss_n) && !busy && $past(busy)));

  // R5
  mosi_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));
endmodule

bind spi_bus_master spi_bus_master_chk #(.NUM_SLAVES(NUM_SLAVES)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .busy  (busy),
  .done  (done),
  .sck   (sck),
  .mosi  (mosi),
  .ss_n  (ss_n)
);

// File: tb/spi_bus_master_tb.sv
module spi_bus_master_tb;
  localparam int DW = 8;
  localparam int NS = 3;
  localparam int VW = 4;
  localparam int LW = 4;
  localparam int IW = 2;

  logic clk, arst_n, start, cpol, cpha, miso;
  logic [DW-1:0] tx_data, rx_data;
  logic [IW-1:0] slave_idx;
  logic [VW-1:0] clk_div;
  logic [LW-1:0] lead_dly;
  logic sck, mosi, done, busy;
  logic [NS-1:0] ss_n;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  spi_bus_master #(.DATA_W(DW), .NUM_SLAVES(NS), .DIV_W(VW), .DLY_W(LW)) u_dut (
    .clk(clk), .arst_n(arst_n), .start(start), .tx_data(tx_data),
    .slave_idx(slave_idx), .clk_div(clk_div), .cpol(cpol), .cpha(cpha),
    .lead_dly(lead_dly), .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .rx_data(rx_data), .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [NS-1:0] ss;
    logic          sck;
    logic          busy;
    logic          done;
    logic          lead;
  } exp_t;
  exp_t exp_q[$];

  // behavioural slave
  logic [DW-1:0] slave_word, s_tx, s_rx;
  int            s_bits;
  logic          m_cpol, m_cpha, sel_prev, sck_prev;

  always @(negedge clk) begin
    logic sel_now;
    logic lead_e;
    sel_now = ~&ss_n;
    if (sel_now && !sel_prev) begin
      s_tx = slave_word; s_rx = '0; s_bits = 0;
    end else if (sel_now && (sck !== sck_prev)) begin
      lead_e = (sck !== m_cpol);
      if (lead_e ^ m_cpha) begin
        s_rx = {s_rx[DW-2:0], mosi};
        s_bits++;
      end else if (s_bits > 0 && s_bits < DW) begin
        s_tx = {s_tx[DW-2:0], 1'b0};
      end
    end
    miso = sel_now ? s_tx[DW-1] : 1'b1;
    sel_prev = sel_now;
    sck_prev = sck;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, expv);
    end
  endtask

  task automatic idle_check(input string tag);
    chk(ss_n == {NS{1'b1}}, {tag, " ss_n idle"}, 32'(ss_n), 32'((1 << NS) - 1));
    chk(sck == cpol, {tag, " sck idle level"}, 32'(sck), 32'(cpol));
    chk(!busy && !done, {tag, " busy/done idle"}, {30'd0, busy, done}, 32'd0);
  endtask

  task automatic run_xfer(input logic [DW-1:0] tx, input logic [DW-1:0] sw,
                          input logic [IW-1:0] idx, input int dv, input int dl,
                          input logic pol, input logic pha, input bit interfere);
    logic [NS-1:0] ss_exp;
    exp_t e;
    int c;
    string rt;
    @(negedge clk);
    tx_data = tx; slave_word = sw; slave_idx = idx;
    clk_div = VW'(dv); lead_dly = LW'(dl); cpol = pol; cpha = pha;
    m_cpol = pol; m_cpha = pha; start = 1'b1;
    ss_exp = {NS{1'b1}};
    if (int'(idx) < NS) ss_exp[idx] = 1'b0;
    for (int i = 0; i <= dl; i++) exp_q.push_back('{ss_exp, pol, 1'b1, 1'b0, 1'b1});
    for (int h = 0; h <= 2 * DW; h++)
      for (int r = 0; r <= dv; r++)
        exp_q.push_back('{ss_exp, pol ^ h[0], 1'b1, 1'b0, (h == 0)});
    exp_q.push_back('{{NS{1'b1}}, pol, 1'b0, 1'b1, 1'b0});
    c = 0;
    @(negedge clk);
    while (exp_q.size() > 0) begin
      c++;
      e = exp_q.pop_front();
      rt = interfere ? "R9" : "";
      chk(ss_n == e.ss, {rt, " R2 ss_n"}, 32'(ss_n), 32'(e.ss));
      chk(sck == e.sck, {rt, e.lead ? " R3 sck before first edge" : " R4 sck"}, 32'(sck), 32'(e.sck));
      chk(busy == e.busy, {rt, " R8 busy"}, 32'(busy), 32'(e.busy));
      chk(done == e.done, {rt, " R8 done"}, 32'(done), 32'(e.done));
      if (c == 1 && !pha)
        chk(mosi == tx[DW-1], " R5 MSB presented at select", 32'(mosi), 32'(tx[DW-1]));
      if (e.done) begin
        chk(rx_data == ((int'(idx) < NS) ? sw : {DW{1'b1}}), {rt, " R7 rx_data"},
            32'(rx_data), 32'((int'(idx) < NS) ? sw : {DW{1'b1}}));
        if (int'(idx) < NS)
          chk(s_rx == tx, {rt, pha ? " R6 slave received" : " R5 slave received"}, 32'(s_rx), 32'(tx));
      end
      if (c == 1 && interfere) begin
        tx_data = ~tx; slave_idx = idx + 2'd1; clk_div = ~VW'(dv);
        lead_dly = ~LW'(dl); cpol = ~pol; cpha = ~pha;
      end else if (c == 1) begin
        start = 1'b0;
      end
      if (c == 3 && interfere) begin
        start = 1'b0; tx_data = tx; slave_idx = idx; clk_div = VW'(dv);
        lead_dly = LW'(dl); cpol = pol; cpha = pha;
      end
      @(negedge clk);
    end
    idle_check("R8 after done");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; start = 1'b0; tx_data = '0; slave_idx = '0; clk_div = '0;
    cpol = 1'b0; cpha = 1'b0; lead_dly = '0; slave_word = '0;
    m_cpol = 1'b0; m_cpha = 1'b0; sel_prev = 1'b0; sck_prev = 1'b0;
    s_tx = '0; s_rx = '0; s_bits = 0; miso = 1'b1;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ss_n == {NS{1'b1}}, "R1 ss_n after reset", 32'(ss_n), 32'((1 << NS) - 1));
    chk(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi after reset", {30'd0, sck, mosi}, 32'd0);
    chk(!busy && !done, "R1 busy/done after reset", {30'd0, busy, done}, 32'd0);
    // R4 idle clock follows cpol input
    @(negedge clk); cpol = 1'b1; @(negedge clk); @(negedge clk);
    idle_check("R4 idle cpol=1");
    cpol = 1'b0; @(negedge clk); @(negedge clk);
    idle_check("R4 idle cpol=0");

    run_xfer(8'hA5, 8'h3C, 2'd0, 0, 0, 1'b0, 1'b0, 1'b0);
    run_xfer(8'h81, 8'h7E, 2'd1, 1, 2, 1'b0, 1'b1, 1'b0);
    run_xfer(8'h5A, 8'hC3, 2'd2, 2, 0, 1'b1, 1'b0, 1'b0);
    run_xfer(8'h0F, 8'hF0, 2'd0, 3, 5, 1'b1, 1'b1, 1'b0);
    run_xfer(8'h96, 8'h12, 2'd3, 0, 1, 1'b0, 1'b0, 1'b0);
    run_xfer(8'hE7, 8'h18, 2'd1, 1, 1, 1'b0, 1'b1, 1'b1);
    run_xfer(8'h00, 8'hFF, 2'd2, 15, 15, 1'b1, 1'b1, 1'b0);
    run_xfer(8'hFF, 8'h00, 2'd0, 15, 15, 1'b0, 1'b0, 1'b0);
    run_xfer(8'h6B, 8'hB6, 2'd1, 0, 0, 1'b1, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule